// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block takes a snapshot of the free-running system time when a packet that qualifies for timestamping crosses the transmit or receive stamp point. The snapshot is held in a pair of 32-bit words, one low and one high, and a valid flag is set. The value stays there until software reads the high word, and that read frees the latch for the next packet. One copy of the block serves the transmit direction and another serves the receive direction.

Only one stamp can be pending at a time. A packet that qualifies while a stamp is still held is not stamped, so software knows the held value belongs to the one outstanding packet. A control port writes the enable bit and a capture-mode field as a pair. The mode field is stored and read back for the packet classifier next to this block. Packet parsing and conversion to nanoseconds happen outside the block.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset, stamp_valid is 0, stamp_lo and stamp_hi are 0, and ctl_rdata is 0 (capture disabled, mode 0).
- R2: A cycle with ctl_wr high replaces both the enable bit and the mode field with ctl_wr_en and ctl_wr_mode. No earlier value survives the write. From the next cycle, ctl_rdata shows bit 0 = valid, bit 1 = enable, and bits [2+MODE_W-1:2] = mode, with all higher bits 0.
- R3: When enabled, stamp_req high and no stamp held, the next cycle shows stamp_valid = 1, stamp_lo = time_now[31:0] and stamp_hi = time_now[63:32]. Both words come from the same sampled cycle.
- R4: While a stamp is held and rd_hi is low, stamp_req is ignored: both stamp words and stamp_valid stay unchanged.
- R5: rd_hi while a stamp is held and stamp_req is low clears stamp_valid in the next cycle. The stamp words keep their value.
- R6: stamp_req in the same cycle as a releasing rd_hi (enabled) is captured. stamp_valid stays 1 and the words take the new snapshot.
- R7: While the enable bit is 0, stamp_req has no effect on the stamp words or on stamp_valid. The enable value that counts is the one held before any write in the same cycle.
- R8: A control write with ctl_wr_en = 0 clears stamp_valid in the next cycle. This holds even when stamp_req or rd_hi is high in that cycle, and no capture is made.
- R9: rd_hi while no stamp is held changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current system time snapshot |
| stamp_req | input | 1 | Qualifying packet at the stamp point (one-cycle strobe) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wr_en | input | 1 | Enable value written by ctl_wr |
| ctl_wr_mode | input | 3 | Capture mode value written by ctl_wr |
| rd_hi | input | 1 | Read strobe of the high stamp word; releases the latch |
| stamp_lo | output | 32 | Held stamp, low word |
| stamp_hi | output | 32 | Held stamp, high word |
| stamp_valid | output | 1 | A stamp is held |
| ctl_rdata | output | 32 | Control register readback |

## Verification
The bench targets the cycle where a high-word read and a new request coincide. A design that gives the read priority would lose that packet and show stamp_valid low. It also sends requests while a stamp is held. A latch that is not locked would overwrite the stamp with a later time, so it would no longer match the pending packet. Disable writes that coincide with requests are checked: a design that lets the capture win would leave a stale valid flag. The bench also tries requests in the very cycle capture is enabled, where a design that uses the newly written enable would stamp a cycle early. Long random runs, compared against a bench model, confirm that both words always come from one snapshot.

// File: rtl/ts_capture_latch.sv
module ts_capture_latch #(
  parameter int WORD_W = 32,
  parameter int MODE_W = 3,
  parameter int CTL_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*WORD_W-1:0] time_now,
  input  logic                stamp_req,
  input  logic                ctl_wr,
  input  logic                ctl_wr_en,
  input  logic [MODE_W-1:0]   ctl_wr_mode,
  input  logic                rd_hi,
  output logic [WORD_W-1:0]   stamp_lo,
  output logic [WORD_W-1:0]   stamp_hi,
  output logic                stamp_valid,
  output logic [CTL_W-1:0]    ctl_rdata
);
  localparam int PAD_W = CTL_W - 2 - MODE_W;

  logic              en_q;
  logic [MODE_W-1:0] mode_q;
  logic              valid_q;
  logic [WORD_W-1:0] lo_q, hi_q;

  wire disabling = ctl_wr & ~ctl_wr_en;
  wire capture   = en_q & stamp_req & (~valid_q | rd_hi) & ~disabling;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= '0;
      valid_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (ctl_wr) begin
        en_q   <= ctl_wr_en;
        mode_q <= ctl_wr_mode;
      end
      if (capture) begin
        lo_q <= time_now[WORD_W-1:0];
        hi_q <= time_now[2*WORD_W-1:WORD_W];
      end
      if (disabling)    valid_q <= 1'b0;
      else if (capture) valid_q <= 1'b1;
      else if (rd_hi)   valid_q <= 1'b0;
    end
  end

  assign stamp_lo    = lo_q;
  assign stamp_hi    = hi_q;
  assign stamp_valid = valid_q;
  assign ctl_rdata   = {{PAD_W{1'b0}}, mode_q, en_q, valid_q};

  AST_CAPTURE_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[1] && stamp_req && !stamp_valid && !(ctl_wr && !ctl_wr_en)
    |=> stamp_valid && stamp_lo == $past(time_now[WORD_W-1:0])
        && stamp_hi == $past(time_now[2*WORD_W-1:WORD_W])); // R3

  AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid && !rd_hi |=> $stable(stamp_lo) && $stable(stamp_hi)); // R4

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid && rd_hi && !stamp_req |=> !stamp_valid && $stable(stamp_hi)); // R5

  AST_REARM_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid && rd_hi && stamp_req && ctl_rdata[1] && !(ctl_wr && !ctl_wr_en)
    |=> stamp_valid && stamp_hi == $past(time_now[2*WORD_W-1:WORD_W])); // R6

  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[1] && !stamp_valid |=> !stamp_valid && $stable(stamp_lo)); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wr_en |=> !stamp_valid && !ctl_rdata[1]); // R8

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_valid && !stamp_req |=> !stamp_valid); // R9
endmodule

// File: tb/tb_ts_capture_latch.sv
module tb_ts_capture_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        stamp_req = 1'b0, ctl_wr = 1'b0, ctl_wr_en = 1'b0, rd_hi = 1'b0;
  logic [2:0]  ctl_wr_mode = '0;
  logic [31:0] stamp_lo, stamp_hi, ctl_rdata;
  logic        stamp_valid;

  int n_chk = 0, n_fail = 0;
  logic        m_en = 0, m_valid = 0;
  logic [2:0]  m_mode = 0;
  logic [31:0] m_lo = 0, m_hi = 0;

  always #10 clk = ~clk;

  ts_capture_latch dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .stamp_req(stamp_req),
    .ctl_wr(ctl_wr), .ctl_wr_en(ctl_wr_en), .ctl_wr_mode(ctl_wr_mode),
    .rd_hi(rd_hi), .stamp_lo(stamp_lo), .stamp_hi(stamp_hi),
    .stamp_valid(stamp_valid), .ctl_rdata(ctl_rdata));

  function automatic logic [31:0] exp_ctl();
    return {27'd0, m_mode, m_en, m_valid};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " lo"}, stamp_lo, m_lo);
    check({tag, " hi"}, stamp_hi, m_hi);
    check({tag, " valid"}, {31'd0, stamp_valid}, {31'd0, m_valid});
    check({tag, " ctl"}, ctl_rdata, exp_ctl());
  endtask

  task automatic cyc(string tag, logic req, logic wr, logic wen, logic [2:0] md,
                     logic rh, logic [63:0] t);
    logic dis, cap;
    @(negedge clk);
    stamp_req = req; ctl_wr = wr; ctl_wr_en = wen; ctl_wr_mode = md;
    rd_hi = rh; time_now = t;
    dis = wr && !wen;
    cap = m_en && req && (!m_valid || rh) && !dis;
    if (cap) begin m_lo = t[31:0]; m_hi = t[63:32]; end
    if (dis) m_valid = 0; else if (cap) m_valid = 1; else if (rh) m_valid = 0;
    if (wr) begin m_en = wen; m_mode = md; end
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1588));
    repeat (3) @(posedge clk);
    #1; check_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    // R7: request while disabled
    cyc("R7 disabled req", 1, 0, 0, 0, 0, 64'h1111_2222_3333_4444);
    // R2: enable write with mode; request same cycle uses old enable (R7)
    cyc("R2/R7 enable write", 1, 1, 1, 3'd5, 0, 64'h0101_0101_0202_0202);
    // R3: capture
    cyc("R3 capture", 1, 0, 0, 0, 0, 64'hDEAD_BEEF_CAFE_F00D);
    // R4: ignored while held
    cyc("R4 locked", 1, 0, 0, 0, 0, 64'h9999_8888_7777_6666);
    cyc("R4 locked again", 1, 0, 0, 0, 0, 64'h5555_4444_3333_2222);
    // R6: release and capture same cycle
    cyc("R6 rearm", 1, 0, 0, 0, 1, 64'hA5A5_A5A5_5A5A_5A5A);
    // R5: release
    cyc("R5 release", 0, 0, 0, 0, 1, 64'h0);
    // R9: idle read
    cyc("R9 idle read", 0, 0, 0, 0, 1, 64'h0);
    cyc("R3 capture2", 1, 0, 0, 0, 0, 64'hFFFF_FFFF_0000_0001);
    // R2: rewrite mode while enabled, replaces fields
    cyc("R2 mode rewrite", 0, 1, 1, 3'd2, 0, 64'h0);
    // R8: disable with coincident request and read
    cyc("R8 disable", 1, 1, 0, 3'd7, 1, 64'h1234_5678_9ABC_DEF0);
    cyc("R7 after disable", 1, 0, 0, 0, 0, 64'h0BAD_0BAD_0BAD_0BAD);
    cyc("R2 reenable", 0, 1, 1, 3'd1, 0, 64'h0);
    for (int i = 0; i < 3000; i++) begin
      logic wr, wen;
      wr  = ($urandom_range(0, 9) == 0);
      wen = ($urandom_range(0, 4) != 0);
      cyc("R3/R4/R5/R6/R8 random", $urandom_range(0, 1) == 1, wr, wen,
          3'($urandom_range(0, 7)), $urandom_range(0, 3) == 0,
          {$urandom, $urandom});
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule